// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This block watches the two wires of an I2C bus from the slave side. It finds each start condition and collects the first byte that follows it. It then decides whether the bus master is calling this device. A call counts when the seven high bits of that byte equal a programmable device address, or when the byte is the all-zero general call. Bytes that come later in the same transfer are not examined.

The result is held in two sticky flags. One flag records any address hit, including a general call. The other flag records general calls only. Host software reads and writes a small register port. Through it, software sets the device address and a format bit, and it reads and clears the flags. A flag clears only when software writes a zero to it after it has read that flag as one. When the format bit selects clocked synchronous serial operation, address recognition is switched off.

Top module: `i2cadr_top`

## Requirements
- R1: After reset the address/format register reads 0x00 and both flags read 0.
- R2: A host write with `regSel`=0 stores `wrData` in the address/format register. Bits 7..1 hold the device address and bit 0 holds the format bit (0 = I2C, 1 = clocked synchronous serial). Reading with `regSel`=0 returns the stored value.
- R3: When the first byte after a start has bits 7..1 equal to the stored address, the match flag (status bit 1) sets whatever the R/W bit 0 is, and the general call flag (status bit 0) stays 0.
- R4: When the first byte after a start is 0x00, both status bit 1 and status bit 0 set.
- R5: Bytes after the first one in a transfer never set a flag.
- R6: A repeated start, meaning a start with no stop before it, begins a fresh first-byte capture, and that byte is compared.
- R7: While format bit 0 of the address/format register is 1, neither flag can set.
- R8: A flag clears on a status write (`regSel`=1) of 0 to its bit, but only if the flag was read as 1 since it was last cleared. A write of 0 without that read leaves the flag set.
- R9: A status write of 1 to a flag bit has no effect on that flag.
- R10: If a hardware set and a permitted clearing write fall in the same cycle, the flag stays set.
- R11: Bits clocked on the bus after a stop, with no new start, are ignored.
- R12: A first byte whose bits 7..1 differ from the stored address and that is not 0x00 leaves both flags at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock wire, asynchronous to `clk` |
| sda | input | 1 | Bus data wire, asynchronous to `clk` |
| regSel | input | 1 | 0 = address/format register, 1 = status register |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe, used to arm flag clearing |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Read data of the selected register; status holds match in bit 1 and general call in bit 0 |

## Verification
Each bus wire passes through two synchronising flops and one edge-detect flop. A flag therefore goes high on the third rising clock edge after the SCL rise that carries the eighth bit. Register writes appear at `rdData` after the next edge, and reads are combinational. The bench holds every SCL phase for four clock periods and samples the status only after the ninth bus clock, which is well past the due edge. The same-cycle set-versus-clear case is the one exception: that test counts exactly two falling edges after the eighth SCL rise and raises the clearing write so that it is sampled on the third rising edge, the edge where the set lands.

// File: rtl/i2cadr_pkg.sv
package i2cadr_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_DATA = 2'd2
  } busState_e;

  // strobes from the bus control to the address datapath
  typedef struct packed {
    logic shiftEn;    // sample bitVal into the frame shifter
    logic frameDone;  // this shift completes the first frame
    logic bitVal;     // synchronised data level at the sample point
  } ctlStrobe_t;

endpackage

// File: rtl/i2cadr_ctrl.sv
module i2cadr_ctrl
  import i2cadr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclPin,
  input  logic       sdaPin,
  output ctlStrobe_t strobe
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic startDet, stopDet, sclRise;
  busState_e state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;

  // both bus wires idle high, so the synchronisers reset to 1
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclPin;
          sdaSync <= sdaPin;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclPin};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaPin};
        end
      end
    end
  endgenerate

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign startDet = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopDet  = sclNow && sclPrev && !sdaPrev && sdaNow;
  assign sclRise  = sclNow && !sclPrev;

  always_comb begin
    stateNxt  = state;
    bitCntNxt = bitCnt;
    if (startDet) begin
      stateNxt  = BUS_ADDR;
      bitCntNxt = '0;
    end else if (stopDet) begin
      stateNxt  = BUS_IDLE;
      bitCntNxt = '0;
    end else if (state == BUS_ADDR && sclRise) begin
      if (bitCnt == LAST_BIT) begin
        stateNxt  = BUS_DATA;
        bitCntNxt = '0;
      end else begin
        bitCntNxt = bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= BUS_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
    end
  end

  always_comb begin
    strobe.shiftEn   = (state == BUS_ADDR) && sclRise;
    strobe.frameDone = strobe.shiftEn && (bitCnt == LAST_BIT);
    strobe.bitVal    = sdaNow;
  end

endmodule

// File: rtl/i2cadr_dp.sv
module i2cadr_dp
  import i2cadr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W:0]   wrData,
  output logic [ADDR_W:0]   rdData,
  output logic [ADDR_W:0]   addrFmt,
  output logic              matchFlag,
  output logic              gcFlag
);

  localparam int FRAME_W   = ADDR_W + 1;
  localparam int NUM_FLAGS = 2;
  localparam int GC_IDX    = 0;
  localparam int MATCH_IDX = 1;

  logic [FRAME_W-2:0]   shiftReg;
  logic [FRAME_W-1:0]   frame;
  logic                 addrHit, gcHit, i2cMode;
  logic                 wrStat, rdStat;
  logic [NUM_FLAGS-1:0] setVec, flagVec, armVec;

  // address/format register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrFmt <= '0;
    else if (wrEn && !regSel) addrFmt <= wrData;
  end

  // first-frame shifter, most significant bit first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[FRAME_W-3:0], strobe.bitVal};
  end

  assign frame   = {shiftReg, strobe.bitVal};
  assign i2cMode = !addrFmt[0];
  assign addrHit = frame[FRAME_W-1:1] == addrFmt[FRAME_W-1:1];
  assign gcHit   = frame == '0;

  assign setVec[MATCH_IDX] = strobe.frameDone && i2cMode && (addrHit || gcHit);
  assign setVec[GC_IDX]    = strobe.frameDone && i2cMode && gcHit;

  assign wrStat = wrEn && regSel;
  assign rdStat = rdEn && regSel;

  // each flag: set by hardware, cleared by zero-write once armed by a read of 1
  generate
    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
      logic clrOk;
      assign clrOk = wrStat && !wrData[k] && armVec[k];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagVec[k] <= 1'b0;
          armVec[k]  <= 1'b0;
        end else if (setVec[k]) begin
          flagVec[k] <= 1'b1;
        end else if (clrOk) begin
          flagVec[k] <= 1'b0;
          armVec[k]  <= 1'b0;
        end else if (rdStat && flagVec[k]) begin
          armVec[k]  <= 1'b1;
        end
      end
    end
  endgenerate

  assign matchFlag = flagVec[MATCH_IDX];
  assign gcFlag    = flagVec[GC_IDX];

  always_comb begin
    rdData = '0;
    if (regSel) rdData[NUM_FLAGS-1:0] = flagVec;
    else        rdData = addrFmt;
  end

endmodule

// File: rtl/i2cadr_top.sv
module i2cadr_top
  import i2cadr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            scl,
  input  logic            sda,
  input  logic            regSel,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [ADDR_W:0] wrData,
  output logic [ADDR_W:0] rdData
);

  ctlStrobe_t      strobe;
  logic [ADDR_W:0] addrFmt;
  logic            matchFlag;
  logic            gcFlag;

  i2cadr_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BITS (ADDR_W + 1)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclPin(scl),
    .sdaPin(sda),
    .strobe(strobe)
  );

  i2cadr_dp #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regSel   (regSel),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .wrData   (wrData),
    .rdData   (rdData),
    .addrFmt  (addrFmt),
    .matchFlag(matchFlag),
    .gcFlag   (gcFlag)
  );

endmodule

// File: rtl/i2cadr_chk.sv
module i2cadr_chk #(
  parameter int ADDR_W = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            regSel,
  input logic            wrEn,
  input logic [ADDR_W:0] wrData,
  input logic [ADDR_W:0] addrFmt,
  input logic            matchFlag,
  input logic            gcFlag,
  input logic            frameDone
);

  // R2
  addr_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && !regSel) |-> addrFmt == $past(wrData));

  // R4
  gc_implies_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gcFlag) |-> matchFlag);

  // R5
  set_on_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(matchFlag) || $rose(gcFlag)) |-> $past(frameDone));

  // R7
  fmt_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrFmt[0]) |-> !($rose(matchFlag) || $rose(gcFlag)));

  // R8
  match_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(matchFlag) |-> $past(wrEn && regSel && !wrData[1]));

  // R9
  gc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gcFlag) |-> $past(wrEn && regSel && !wrData[0]));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameDone && !addrFmt[0] && matchFlag) |-> matchFlag);

endmodule

bind i2cadr_top i2cadr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regSel   (regSel),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .addrFmt  (addrFmt),
  .matchFlag(matchFlag),
  .gcFlag   (gcFlag),
  .frameDone(strobe.frameDone)
);

// File: tb/sim_i2cadr_top.sv
module sim_i2cadr_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, scl, sda, regSel, wrEn, rdEn;
  logic [7:0] wrData, rdData;
  int nChecks = 0;
  int nFails  = 0;

  localparam logic [7:0] MY_ADDR = 8'hA4;  // device address 0x52, I2C format

  i2cadr_top u0 (
    .clk(clk), .rstN(rstN), .scl(scl), .sda(sda),
    .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] d);
    regSel = sel; wrData = d; wrEn = 1'b1;
    idle(1);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [7:0] d);
    regSel = sel; rdEn = 1'b1;
    #1 d = rdData;
    idle(1);
    rdEn = 1'b0;
  endtask

  task automatic busStart;
    sda = 1'b1; idle(4);
    scl = 1'b1; idle(4);
    sda = 1'b0; idle(4);
    scl = 1'b0; idle(4);
  endtask

  task automatic busStop;
    sda = 1'b0; idle(4);
    scl = 1'b1; idle(4);
    sda = 1'b1; idle(4);
  endtask

  // eight data bits then a ninth clock with sda released;
  // clrLast lines a clearing write up with the flag-set edge
  task automatic sendByte(input logic [7:0] b, input logic clrLast);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0;
      sda = b[i]; idle(4);
      scl = 1'b1;
      if (clrLast && i == 0) begin
        idle(2);
        regSel = 1'b1; wrData = 8'h00; wrEn = 1'b1;
        idle(1);
        wrEn = 1'b0;
        idle(1);
      end else begin
        idle(4);
      end
      scl = 1'b0; idle(2);
    end
    sda = 1'b1; idle(4);
    scl = 1'b1; idle(4);
    scl = 1'b0; idle(4);
  endtask

  task automatic transfer(input logic [7:0] b);
    busStart; sendByte(b, 1'b0); busStop;
  endtask

  task automatic clearFlags;
    logic [7:0] d;
    readReg(1'b1, d);
    writeReg(1'b1, 8'h00);
  endtask

  task automatic testReset;
    logic [7:0] d;
    readReg(1'b0, d); check("R1 address reg", d, 8'h00);
    readReg(1'b1, d); check("R1 status", d, 8'h00);
  endtask

  task automatic testRegister;
    logic [7:0] d;
    writeReg(1'b0, 8'h5B); readReg(1'b0, d); check("R2 readback 5B", d, 8'h5B);
    writeReg(1'b0, MY_ADDR); readReg(1'b0, d); check("R2 readback A4", d, MY_ADDR);
  endtask

  task automatic testMatch;
    logic [7:0] d;
    transfer(8'hA4); readReg(1'b1, d); check("R3 write-direction match", d, 8'h02);
    writeReg(1'b1, 8'h00); readReg(1'b1, d); check("R8 clear after read", d, 8'h00);
    transfer(8'hA5); readReg(1'b1, d); check("R3 read-direction match", d, 8'h02);
    clearFlags;
  endtask

  task automatic testMismatch;
    logic [7:0] d;
    transfer(8'hA6); readReg(1'b1, d); check("R12 other address", d, 8'h00);
    transfer(8'h24); readReg(1'b1, d); check("R12 top bit differs", d, 8'h00);
  endtask

  task automatic testGeneralCall;
    logic [7:0] d;
    transfer(8'h00); readReg(1'b1, d); check("R4 general call", d, 8'h03);
    writeReg(1'b1, 8'h00); readReg(1'b1, d); check("R8 clear both", d, 8'h00);
  endtask

  task automatic testLaterFrame;
    logic [7:0] d;
    busStart; sendByte(8'h10, 1'b0); sendByte(8'hA4, 1'b0); sendByte(8'h00, 1'b0); busStop;
    readReg(1'b1, d); check("R5 later frames ignored", d, 8'h00);
  endtask

  task automatic testRepeatedStart;
    logic [7:0] d;
    busStart; sendByte(8'h10, 1'b0); busStart; sendByte(8'hA4, 1'b0); busStop;
    readReg(1'b1, d); check("R6 repeated start", d, 8'h02);
    clearFlags;
  endtask

  task automatic testAfterStop;
    logic [7:0] d;
    sendByte(8'hA4, 1'b0); sendByte(8'h00, 1'b0);
    readReg(1'b1, d); check("R11 bits after stop", d, 8'h00);
  endtask

  task automatic testFormat;
    logic [7:0] d;
    writeReg(1'b0, 8'hA5);
    transfer(8'hA4); readReg(1'b1, d); check("R7 format blocks match", d, 8'h00);
    transfer(8'h00); readReg(1'b1, d); check("R7 format blocks general call", d, 8'h00);
    writeReg(1'b0, MY_ADDR);
  endtask

  task automatic testNoReadClear;
    logic [7:0] d;
    transfer(8'hA4);
    writeReg(1'b1, 8'h00); readReg(1'b1, d); check("R8 zero-write without read", d, 8'h02);
    writeReg(1'b1, 8'h00); readReg(1'b1, d); check("R8 zero-write after read", d, 8'h00);
  endtask

  task automatic testWriteOne;
    logic [7:0] d;
    transfer(8'h00); readReg(1'b1, d);
    writeReg(1'b1, 8'hFF); readReg(1'b1, d); check("R9 write of ones", d, 8'h03);
    writeReg(1'b1, 8'h00); readReg(1'b1, d); check("R9 then cleared", d, 8'h00);
  endtask

  task automatic testSetWins;
    logic [7:0] d;
    transfer(8'hA4); readReg(1'b1, d);
    busStart; sendByte(8'hA4, 1'b1); busStop;
    readReg(1'b1, d); check("R10 set beats clear", d, 8'h02);
    clearFlags;
    readReg(1'b1, d); check("R10 cleared afterwards", d, 8'h00);
  endtask

  initial begin
    rstN = 1'b0; scl = 1'b1; sda = 1'b1;
    regSel = 1'b0; wrEn = 1'b0; rdEn = 1'b0; wrData = 8'h00;
    idle(5);
    rstN = 1'b1;
    idle(3);
    testReset;
    testRegister;
    testMatch;
    testMismatch;
    testGeneralCall;
    testLaterFrame;
    testRepeatedStart;
    testAfterStop;
    testFormat;
    testNoReadClear;
    testWriteOne;
    testSetWins;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule